// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front End

This block sits between a simple processor bus and the serial shifters of a byte-wide serial port. It decodes a window of eight word-spaced registers, each carrying only an 8-bit value, and gives software four fixed identification bytes, a data port, a combined status/control byte and a 16-bit baud divisor split over two bytes. The bit-level shifting and the baud tick are done elsewhere. This block only exchanges bytes with those shifters through valid/take handshakes, and it drives the divisor value they use.

Received bytes go into a small receive FIFO that software drains by reading the data port. Transmit bytes are written into a single holding register that the transmit shifter empties. One level-sensitive interrupt line combines "receive data waiting" and "transmitter ready for a byte". Each of the two sources has its own enable bit in the status byte. The same byte also carries two sticky error flags that software clears by writing a zero to them.

Top module: `sio_ctrl_regs`

## Requirements
- R1: After reset the status byte reads 8'hA0 (transmit holding empty at bit 7, receive FIFO empty at bit 5, every other bit 0), `irq` is 0, `tx_valid` is 0 and `baud_div` equals the BAUD_RST parameter.
- R2: Reads at byte offsets 0, 4, 8 and 12 return bytes 0 to 3 of the ID_WORD parameter (byte i is ID_WORD[8i+7:8i]). Writes to these offsets change nothing that can be read back.
- R3: Offset 24 holds the low divisor byte and offset 28 the high divisor byte. Both can be written and read back, and `baud_div` is {high, low}. It changes only on a write to one of these two offsets.
- R4: A write to the data port (offset 16) is accepted only while status bit 7 is 1. It loads `tx_byte`, raises `tx_valid` and clears bit 7 in the following cycle. A write while bit 7 is 0 leaves `tx_byte` unchanged.
- R5: A cycle with `tx_take` high while `tx_valid` is high empties the holding register, so `tx_valid` falls and status bit 7 returns to 1 in the next cycle.
- R6: Bytes strobed in by `rx_valid` are returned by data-port reads in arrival order. Each read with the FIFO not empty removes one byte, and the FIFO holds RX_DEPTH bytes.
- R7: Status bit 3 is 1 exactly when the receive FIFO holds RX_DEPTH bytes. Bit 4 is 1 exactly when it holds RX_DEPTH-1 bytes. Bit 5 is 1 exactly when it holds none.
- R8: A byte arriving while the FIFO is full and no read takes place in the same cycle is discarded and sets the overflow flag, status bit 1.
- R9: A byte arriving with `rx_frame_err` high sets the frame-error flag, status bit 0. The byte itself is stored.
- R10: A status write clears bit 0 or bit 1 where the written bit is 0 and leaves it unchanged where the written bit is 1. Written values at bits 3, 4, 5 and 7 have no effect.
- R11: Status bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable) take the written value on every status write and read back as written.
- R12: `irq` is 1 exactly when (bit 2 and not bit 5) or (bit 6 and bit 7).
- R13: A data-port read with the FIFO empty returns the byte most recently removed (0 if none since reset) and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_valid | input | 1 | One-cycle strobe: received byte present |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Received byte had a bad stop bit |
| tx_valid | output | 1 | Holding register holds a byte for the shifter |
| tx_byte | output | 8 | Byte offered to the transmit shifter |
| tx_take | input | 1 | Shifter takes the held byte this cycle |
| baud_div | output | 16 | Baud divisor {high byte, low byte} |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational from registered state. The bench therefore drives an access half a cycle before a rising edge and samples `bus_rdata` just after driving it. The register updates and the pop that the same access causes appear one edge later. Every write, `rx_valid` strobe and `tx_take` pulse takes effect at the next rising edge. Status bits, `irq`, `tx_valid`, `tx_byte` and `baud_div` are all checked at the following falling edge, one cycle after the stimulus and before anything else is applied. The sweeps step through every FIFO level, every status write value and every transmit byte, and compute the expected status byte from the bit positions in the requirements.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

  // Register index = byte address bits [4:2]; order fixed by the bus map.
  typedef enum logic [2:0] {
    REG_ID0     = 3'd0,
    REG_ID1     = 3'd1,
    REG_ID2     = 3'd2,
    REG_ID3     = 3'd3,
    REG_DATA    = 3'd4,
    REG_STAT    = 3'd5,
    REG_BAUD_LO = 3'd6,
    REG_BAUD_HI = 3'd7
  } sio_reg_e;

  // Status byte bit positions (software decodes these).
  localparam int ST_FERR    = 0;
  localparam int ST_OVF     = 1;
  localparam int ST_RXIE    = 2;
  localparam int ST_RXFULL  = 3;
  localparam int ST_RXLAST  = 4;
  localparam int ST_RXEMPTY = 5;
  localparam int ST_TXIE    = 6;
  localparam int ST_TXEMPTY = 7;

  localparam int NUM_ERR = 2;

endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [W-1:0]                push_data,
  input  logic                        pop,
  output logic [W-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]  level,
  output logic                        empty,
  output logic                        full,
  output logic                        one_left,
  output logic                        dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH-1);
  localparam logic [AW-1:0] PTR_TOP  = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  last_q, last_d;
  logic          pop_eff, push_eff;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_FULL);
  assign one_left = (cnt_q == CNT_LAST);
  assign level    = cnt_q;

  always_comb begin
    pop_eff  = pop && !empty;
    push_eff = push && (!full || pop_eff);
    dropped  = push && !push_eff;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    last_d   = last_q;
    cnt_d    = cnt_q;
    if (push_eff) wr_ptr_d = (wr_ptr_q == PTR_TOP) ? '0 : wr_ptr_q + 1'b1;
    if (pop_eff) begin
      rd_ptr_d = (rd_ptr_q == PTR_TOP) ? '0 : rd_ptr_q + 1'b1;
      last_d   = mem[rd_ptr_q];
    end
    case ({push_eff, pop_eff})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  assign rd_data = empty ? last_q : mem[rd_ptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
    end
  end

  // Storage without reset; written only under push_eff.
  always_ff @(posedge clk) begin
    if (push_eff) mem[wr_ptr_q] <= push_data;
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R6
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rd_ptr_q) && $stable(last_q))); // R13
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R8

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q, data_d;
  logic         accept;

  always_comb begin
    accept  = wr && !valid_q;
    valid_d = valid_q;
    data_d  = data_q;
    if (accept) begin
      valid_d = 1'b1;
      data_d  = wr_data;
    end else if (take) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (accept) data_q <= data_d;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  AST_TX_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && valid_q) |=> $stable(data_q)); // R4
  AST_TX_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && valid_q) |=> !valid_q); // R5

endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] keep_bits,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_wr && !keep_bits[i]) flag_d[i] = 1'b0;
      if (set[i])                  flag_d[i] = 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_wr && !keep_bits[i])) |=> flag_q[i]); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_regs_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter int          RX_DEPTH = 4,
  parameter logic [31:0] ID_WORD  = 32'h5A_3C_01_A7,
  parameter logic [15:0] BAUD_RST = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_frame_err,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_take,
  output logic [15:0]       baud_div,
  output logic              irq
);
  localparam int BW = 8;
  localparam int CW = $clog2(RX_DEPTH+1);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Decode
  sio_reg_e reg_idx;
  logic     wr_hit, rd_hit;
  logic     data_wr, data_rd, stat_wr, blo_wr, bhi_wr;
  always_comb begin
    reg_idx = sio_reg_e'(bus_addr[4:2]);
    wr_hit  = bus_sel && bus_wr;
    rd_hit  = bus_sel && !bus_wr;
    data_wr = wr_hit && (reg_idx == REG_DATA);
    data_rd = rd_hit && (reg_idx == REG_DATA);
    stat_wr = wr_hit && (reg_idx == REG_STAT);
    blo_wr  = wr_hit && (reg_idx == REG_BAUD_LO);
    bhi_wr  = wr_hit && (reg_idx == REG_BAUD_HI);
  end

  // Receive FIFO
  logic [BW-1:0] rx_head;
  logic [CW-1:0] rx_level;
  logic          rx_empty, rx_full, rx_one_left, rx_dropped;

  sio_rx_fifo #(.DEPTH(RX_DEPTH), .W(BW)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (data_rd),
    .rd_data   (rx_head),
    .level     (rx_level),
    .empty     (rx_empty),
    .full      (rx_full),
    .one_left  (rx_one_left),
    .dropped   (rx_dropped)
  );

  // Transmit holding register
  sio_tx_hold #(.W(BW)) u_tx_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (data_wr),
    .wr_data (bus_wdata),
    .take    (tx_take),
    .valid   (tx_valid),
    .data    (tx_byte)
  );

  // Sticky error flags: index 0 frame, index 1 overflow
  logic [NUM_ERR-1:0] err_set, err_flags;
  assign err_set[ST_FERR] = rx_valid && rx_frame_err;
  assign err_set[ST_OVF]  = rx_dropped;

  sio_err_flags #(.N(NUM_ERR)) u_err_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set       (err_set),
    .clr_wr    (stat_wr),
    .keep_bits (bus_wdata[NUM_ERR-1:0]),
    .flags     (err_flags)
  );

  // Interrupt enables and baud divisor
  logic          ie_rx_q, ie_rx_d, ie_tx_q, ie_tx_d;
  logic [BW-1:0] blo_q, blo_d, bhi_q, bhi_d;

  always_comb begin
    ie_rx_d = stat_wr ? bus_wdata[ST_RXIE] : ie_rx_q;
    ie_tx_d = stat_wr ? bus_wdata[ST_TXIE] : ie_tx_q;
    blo_d   = blo_wr  ? bus_wdata : blo_q;
    bhi_d   = bhi_wr  ? bus_wdata : bhi_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ie_rx_q <= 1'b0;
      ie_tx_q <= 1'b0;
      blo_q   <= BAUD_RST[BW-1:0];
      bhi_q   <= BAUD_RST[2*BW-1:BW];
    end else begin
      ie_rx_q <= ie_rx_d;
      ie_tx_q <= ie_tx_d;
      blo_q   <= blo_d;
      bhi_q   <= bhi_d;
    end
  end

  assign baud_div = {bhi_q, blo_q};

  // Status byte and read mux
  logic [BW-1:0] status;
  always_comb begin
    status             = '0;
    status[ST_FERR]    = err_flags[ST_FERR];
    status[ST_OVF]     = err_flags[ST_OVF];
    status[ST_RXIE]    = ie_rx_q;
    status[ST_RXFULL]  = rx_full;
    status[ST_RXLAST]  = rx_one_left;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_TXIE]    = ie_tx_q;
    status[ST_TXEMPTY] = !tx_valid;
  end

  always_comb begin
    case (reg_idx)
      REG_ID0:     bus_rdata = ID_WORD[7:0];
      REG_ID1:     bus_rdata = ID_WORD[15:8];
      REG_ID2:     bus_rdata = ID_WORD[23:16];
      REG_ID3:     bus_rdata = ID_WORD[31:24];
      REG_DATA:    bus_rdata = rx_head;
      REG_STAT:    bus_rdata = status;
      REG_BAUD_LO: bus_rdata = blo_q;
      default:     bus_rdata = bhi_q;
    endcase
  end

  assign irq = (ie_rx_q && !rx_empty) || (ie_tx_q && !tx_valid);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (ie_rx_q || ie_tx_q)); // R12
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_valid && rx_full && !data_rd) |=> err_flags[ST_OVF]); // R8
  AST_BAUD_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(blo_wr || bhi_wr) |=> $stable(baud_div)); // R3
  AST_LEVEL_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({rx_full, rx_one_left, rx_empty}) || (RX_DEPTH == 1)); // R7

endmodule

// File: tb/sio_ctrl_regs_bench.sv
module sio_ctrl_regs_bench;
  localparam int          DEPTH = 4;
  localparam logic [31:0] IDW   = 32'hC4_9E_21_B7;
  localparam logic [15:0] BRST  = 16'h0036;
  localparam logic [4:0] A_ID0 = 5'd0, A_DATA = 5'd16, A_STAT = 5'd20,
                         A_BLO = 5'd24, A_BHI = 5'd28;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, bus_sel, bus_wr, rx_valid, rx_frame_err, tx_take;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rx_byte, tx_byte;
  logic       tx_valid, irq;
  logic [15:0] baud_div;

  sio_ctrl_regs #(.ADDR_W(5), .RX_DEPTH(DEPTH), .ID_WORD(IDW), .BAUD_RST(BRST)) u_sio_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_frame_err(rx_frame_err), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
    .baud_div(baud_div), .irq(irq));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] stat(bit txe, bit tie, int lvl, bit rie, bit ovf, bit fe);
    return {txe, tie, lvl == 0, lvl == DEPTH-1, lvl == DEPTH, rie, ovf, fe};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic fe);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_frame_err = fe;
    @(negedge clk); rx_valid = 0; rx_frame_err = 0;
  endtask

  task automatic take_pulse();
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0; rx_frame_err = 0; tx_take = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", {8'h0, d}, 16'h00A0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tx_valid", {15'h0, tx_valid}, 16'h0);
    chk("R1 baud", baud_div, BRST);

    // R2 ID bytes, writes ignored
    for (int i = 0; i < 4; i++) begin
      rd(A_ID0 + 5'(4*i), d); chk("R2 id", {8'h0, d}, {8'h0, IDW[8*i +: 8]});
      wr(A_ID0 + 5'(4*i), ~IDW[8*i +: 8]);
      rd(A_ID0 + 5'(4*i), d); chk("R2 id after write", {8'h0, d}, {8'h0, IDW[8*i +: 8]});
    end

    // R3 baud divisor
    for (int v = 0; v < 16; v++) begin
      logic [7:0] lo, hi;
      lo = 8'(v * 37 + 5); hi = 8'(255 - v * 13);
      wr(A_BLO, lo); chk("R3 baud lo", baud_div[7:0], {8'h0, lo});
      wr(A_BHI, hi); chk("R3 baud", baud_div, {hi, lo});
      rd(A_BLO, d); chk("R3 read lo", {8'h0, d}, {8'h0, lo});
      rd(A_BHI, d); chk("R3 read hi", {8'h0, d}, {8'h0, hi});
    end

    // R10 R11 R12 status write sweep (FIFO empty, tx empty, no errors)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w; w = 8'(v);
      wr(A_STAT, w);
      chk("R12 irq sweep", {15'h0, irq}, {15'h0, w[6]});
      rd(A_STAT, d); chk("R11 R10 status sweep", {8'h0, d}, {8'h0, stat(1, w[6], 0, w[2], 0, 0)});
    end
    wr(A_STAT, 8'h00);

    // R6 R7 fill levels, R8 overflow
    for (int l = 0; l <= DEPTH; l++) begin
      rd(A_STAT, d); chk("R7 level fill", {8'h0, d}, {8'h0, stat(1, 0, l, 0, 0, 0)});
      if (l < DEPTH) rx_push(8'h30 + 8'(l), 0);
    end
    rx_push(8'hEE, 0);
    rd(A_STAT, d); chk("R8 overflow", {8'h0, d}, {8'h0, stat(1, 0, DEPTH, 0, 1, 0)});
    for (int l = DEPTH; l > 0; l--) begin
      rd(A_DATA, d); chk("R6 order", {8'h0, d}, {8'h0, 8'h30 + 8'(DEPTH - l)});
      rd(A_STAT, d); chk("R7 level drain", {8'h0, d}, {8'h0, stat(1, 0, l-1, 0, 1, 0)});
    end
    // R13 empty read
    rd(A_DATA, d); chk("R13 empty read", {8'h0, d}, {8'h0, 8'h30 + 8'(DEPTH-1)});
    rd(A_STAT, d); chk("R13 still empty", {8'h0, d}, {8'h0, stat(1, 0, 0, 0, 1, 0)});
    rx_push(8'h77, 0);
    rd(A_DATA, d); chk("R13 no pointer move", {8'h0, d}, 16'h0077);
    // R10 write 1 keeps, write 0 clears
    wr(A_STAT, 8'hBB);
    rd(A_STAT, d); chk("R10 keep ovf", {8'h0, d}, {8'h0, stat(1, 0, 0, 0, 1, 0)});
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); chk("R10 clear ovf", {8'h0, d}, {8'h0, stat(1, 0, 0, 0, 0, 0)});

    // R9 frame error
    rx_push(8'h5C, 1);
    rd(A_STAT, d); chk("R9 frame flag", {8'h0, d}, {8'h0, stat(1, 0, 1, 0, 0, 1)});
    rd(A_DATA, d); chk("R9 byte stored", {8'h0, d}, 16'h005C);
    wr(A_STAT, 8'h02);
    rd(A_STAT, d); chk("R10 clear ferr", {8'h0, d}, {8'h0, stat(1, 0, 0, 0, 0, 0)});

    // R12 receive interrupt
    wr(A_STAT, 8'h04); chk("R12 rx en empty", {15'h0, irq}, 16'h0);
    rx_push(8'h11, 0); chk("R12 rx data", {15'h0, irq}, 16'h1);
    rd(A_DATA, d); chk("R12 rx drained", {15'h0, irq}, 16'h0);
    wr(A_STAT, 8'h44); chk("R12 tx ready", {15'h0, irq}, 16'h1);
    wr(A_DATA, 8'h99); chk("R12 tx busy", {15'h0, irq}, 16'h0);
    take_pulse(); chk("R12 tx freed", {15'h0, irq}, 16'h1);
    wr(A_STAT, 8'h00);

    // R4 R5 transmit sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b; b = 8'(v);
      wr(A_DATA, b);
      chk("R4 tx_valid", {15'h0, tx_valid}, 16'h1);
      chk("R4 tx_byte", {8'h0, tx_byte}, {8'h0, b});
      rd(A_STAT, d); chk("R4 bit7 clear", {15'h0, d[7]}, 16'h0);
      wr(A_DATA, ~b); chk("R4 busy ignored", {8'h0, tx_byte}, {8'h0, b});
      take_pulse();
      chk("R5 tx freed", {15'h0, tx_valid}, 16'h0);
      rd(A_STAT, d); chk("R5 bit7 set", {15'h0, d[7]}, 16'h1);
    end

    finish_run();
  end
endmodule